// File: doc/BRIEF.md
# PLL Power-Up Sequencing Controller

This block owns the three control bits of a PLL mode register and moves them through a fixed power-up order. The order is: release bypass, wait a timed interval, release reset, wait for lock, then enable the output. An enable strobe starts the sequence only when all three bits are clear. A disable strobe clears all three bits in one update. On the first enable after reset, the controller first loads a set of configuration registers once: integer-mode divider values (M=0, N=1) and configuration, user and droop words.

The wait after reset release depends on a strap input. When the strap says a lock status exists, the controller waits for the lock input. Without it, the controller counts a fixed interval. Both intervals are derived from a clock-frequency parameter.

While the register reads fully on, the controller also watches the lock input, provided lock status exists. If lock is lost, it forces the PLL off and reloads the configuration. A busy flag covers every running sequence, and strobes that arrive during one are dropped. A one-cycle done pulse marks the end of each sequence.

Top module: `pllseq_ctrl`

## Requirements
- R1: After reset, mode_o is 3'b000, and busy_o, done_o, enabled_o and cfg_wr_o are 0. The config outputs are all zero.
- R2: An accepted enable sets mode bit 1 (bypass off, active low) first. In the cycle it rises, bits 0 (output enable) and 2 (reset release, active low) are still 0.
- R3: Mode bit 2 rises exactly BYP_CYC = CLK_HZ*BYPASS_US/10^6 clock cycles after bit 1 rises.
- R4: With lock_present_i=1, bit 0 rises on the cycle after lock_i is first sampled high with bit 2 set, and never before. With lock_present_i=0, bit 0 rises exactly FIX_CYC = CLK_HZ*FIXED_US/10^6 cycles after bit 2, whatever lock_i does.
- R5: busy_o is high from the cycle after an accepted request until the sequence ends. done_o pulses for one cycle with busy_o low when the enable sequence finishes, and mode_o reads 3'b111 at that point.
- R6: A disable strobe sampled while idle sets mode_o to 3'b000 in the next cycle, in a single step, and pulses done_o.
- R7: An enable strobe sampled while idle with any mode bit set has no effect: mode_o is unchanged and done_o stays low.
- R8: Enable or disable strobes sampled while busy_o is high are dropped and not queued, and the running sequence completes unchanged.
- R9: The first accepted enable after reset spends one extra cycle loading the config outputs. It pulses cfg_wr_o with m_o=0, n_o=1, cfg_o=CFG_VAL, user_o=USER_VAL and droop_o=DROOP_VAL. Bit 1 then rises 2 cycles after the strobe instead of 1. Later enables do not pulse cfg_wr_o.
- R10: enabled_o is 1 exactly when mode_o equals 3'b111.
- R11: Suppose the controller is idle with mode_o=3'b111, lock_present_i=1 and lock_i=0. Then mode_o becomes 3'b000 on the next cycle, and cfg_wr_o and done_o pulse one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_req_i | input | 1 | Enable request strobe |
| dis_req_i | input | 1 | Disable request strobe |
| lock_i | input | 1 | Lock indication from the PLL |
| lock_present_i | input | 1 | Strap: lock status exists |
| mode_o | output | 3 | Mode bits: [0] output enable, [1] bypass off, [2] out of reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| enabled_o | output | 1 | Mode is fully on |
| cfg_wr_o | output | 1 | Pulse when the one-time configuration is loaded |
| m_o | output | MN_W | M divider value |
| n_o | output | MN_W | N divider value |
| cfg_o | output | CFG_W | Configuration word |
| user_o | output | CFG_W | User word |
| droop_o | output | CFG_W | Droop word |

## Verification
The hardest case to reach is lock loss on a PLL that is already fully on. It requires lock_present_i to be set, a completed enable, and the lock input to drop while the controller is idle. The bench's PLL model raises lock a programmable number of cycles after reset release. It can also be told to drop lock, and random operations inject that drop only when the model knows the PLL is fully on with lock status present. Strobes are also injected in the middle of a bypass wait to show they are not queued.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CFG,
    ST_BYP,
    ST_LOCK
  } seq_st_e;

  localparam int MB_OUT = 0;
  localparam int MB_BYP = 1;
  localparam int MB_RST = 2;

  localparam logic [2:0] MODE_OFF = 3'b000;
  localparam logic [2:0] MODE_ON  = 3'b111;

  function automatic int us_to_cycles(input longint clk_hz, input longint us);
    longint c;
    c = (clk_hz * us) / 64'd1_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pllseq_cfg.sv
module pllseq_cfg #(
  parameter int               CFG_W     = 32,
  parameter int               MN_W      = 8,
  parameter logic [CFG_W-1:0] CFG_VAL   = '0,
  parameter logic [CFG_W-1:0] USER_VAL  = '0,
  parameter logic [CFG_W-1:0] DROOP_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic             wr_o,
  output logic [MN_W-1:0]  m_o,
  output logic [MN_W-1:0]  n_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CFG_W-1:0] user_o,
  output logic [CFG_W-1:0] droop_o
);

  localparam logic [MN_W-1:0] M_INT = '0;
  localparam logic [MN_W-1:0] N_INT = MN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o    <= 1'b0;
      m_o     <= '0;
      n_o     <= '0;
      cfg_o   <= '0;
      user_o  <= '0;
      droop_o <= '0;
    end else begin
      wr_o <= load_i;
      if (load_i) begin
        m_o     <= M_INT;
        n_o     <= N_INT;
        cfg_o   <= CFG_VAL;
        user_o  <= USER_VAL;
        droop_o <= DROOP_VAL;
      end
    end
  end

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
#(
  parameter int BYP_CYC = 10,
  parameter int FIX_CYC = 60,
  parameter int CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic             lock_i,
  input  logic             lock_present_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic             cfg_load_o,
  output logic [2:0]       mode_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] BYP_LAST = CNT_W'(BYP_CYC - 1);
  localparam logic [CNT_W-1:0] FIX_LAST = CNT_W'(FIX_CYC - 1);

  seq_st_e    state_q, state_d;
  logic [2:0] mode_q, mode_d;
  logic       done_q, done_d;
  logic       init_q, init_d;
  logic       cfgonly_q, cfgonly_d;
  logic       lock_ok;

  // lock wait ends on lock or on the fixed count, depending on the strap
  assign lock_ok = lock_present_i ? lock_i : (cnt_i == FIX_LAST);

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    done_d    = 1'b0;
    init_d    = init_q;
    cfgonly_d = cfgonly_q;
    tmr_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (mode_q == MODE_ON && lock_present_i && !lock_i) begin
          mode_d    = MODE_OFF;
          init_d    = 1'b0;
          cfgonly_d = 1'b1;
          state_d   = ST_CFG;
        end else if (dis_req_i) begin
          mode_d = MODE_OFF;
          done_d = 1'b1;
        end else if (en_req_i && mode_q == MODE_OFF) begin
          if (!init_q) begin
            state_d = ST_CFG;
          end else begin
            mode_d[MB_BYP] = 1'b1;
            tmr_clr_o      = 1'b1;
            state_d        = ST_BYP;
          end
        end
      end
      ST_CFG: begin
        init_d = 1'b1;
        if (cfgonly_q) begin
          cfgonly_d = 1'b0;
          done_d    = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          mode_d[MB_BYP] = 1'b1;
          tmr_clr_o      = 1'b1;
          state_d        = ST_BYP;
        end
      end
      ST_BYP: begin
        if (cnt_i == BYP_LAST) begin
          mode_d[MB_RST] = 1'b1;
          tmr_clr_o      = 1'b1;
          state_d        = ST_LOCK;
        end
      end
      ST_LOCK: begin
        if (lock_ok) begin
          mode_d[MB_OUT] = 1'b1;
          done_d         = 1'b1;
          state_d        = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_OFF;
      done_q    <= 1'b0;
      init_q    <= 1'b0;
      cfgonly_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      mode_q    <= mode_d;
      done_q    <= done_d;
      init_q    <= init_d;
      cfgonly_q <= cfgonly_d;
    end
  end

  assign tmr_en_o   = (state_q == ST_BYP) || (state_q == ST_LOCK);
  assign cfg_load_o = (state_q == ST_CFG);
  assign mode_o     = mode_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter int               CLK_HZ    = 100_000_000,
  parameter int               BYPASS_US = 10,
  parameter int               FIXED_US  = 60,
  parameter int               CFG_W     = 32,
  parameter int               MN_W      = 8,
  parameter logic [CFG_W-1:0] CFG_VAL   = 32'h0000_4C2D,
  parameter logic [CFG_W-1:0] USER_VAL  = 32'h0010_0000,
  parameter logic [CFG_W-1:0] DROOP_VAL = 32'h0108_C000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic             lock_i,
  input  logic             lock_present_i,
  output logic [2:0]       mode_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             enabled_o,
  output logic             cfg_wr_o,
  output logic [MN_W-1:0]  m_o,
  output logic [MN_W-1:0]  n_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CFG_W-1:0] user_o,
  output logic [CFG_W-1:0] droop_o
);

  localparam int BYP_CYC = us_to_cycles(longint'(CLK_HZ), longint'(BYPASS_US));
  localparam int FIX_CYC = us_to_cycles(longint'(CLK_HZ), longint'(FIXED_US));
  localparam int MAX_CYC = (BYP_CYC > FIX_CYC) ? BYP_CYC : FIX_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             tmr_clr, tmr_en, cfg_load;

  pllseq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .cnt_o  (cnt)
  );

  pllseq_fsm #(
    .BYP_CYC (BYP_CYC),
    .FIX_CYC (FIX_CYC),
    .CNT_W   (CNT_W)
  ) i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_req_i       (en_req_i),
    .dis_req_i      (dis_req_i),
    .lock_i         (lock_i),
    .lock_present_i (lock_present_i),
    .cnt_i          (cnt),
    .tmr_clr_o      (tmr_clr),
    .tmr_en_o       (tmr_en),
    .cfg_load_o     (cfg_load),
    .mode_o         (mode_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  pllseq_cfg #(
    .CFG_W     (CFG_W),
    .MN_W      (MN_W),
    .CFG_VAL   (CFG_VAL),
    .USER_VAL  (USER_VAL),
    .DROOP_VAL (DROOP_VAL)
  ) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load),
    .wr_o    (cfg_wr_o),
    .m_o     (m_o),
    .n_o     (n_o),
    .cfg_o   (cfg_o),
    .user_o  (user_o),
    .droop_o (droop_o)
  );

  assign enabled_o = (mode_o == MODE_ON);

endmodule

// File: rtl/pllseq_ctrl_chk.sv
module pllseq_ctrl_chk #(
  parameter int CFG_W = 32,
  parameter int MN_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_req_i,
  input logic             dis_req_i,
  input logic             lock_i,
  input logic             lock_present_i,
  input logic [2:0]       mode_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             enabled_o,
  input logic             cfg_wr_o,
  input logic [MN_W-1:0]  m_o,
  input logic [MN_W-1:0]  n_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic [CFG_W-1:0] user_o,
  input logic [CFG_W-1:0] droop_o
);

  logic stale;
  assign stale = (mode_o == 3'b111) && lock_present_i && !lock_i;

  assert_bypass_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o[1]) |-> (mode_o[2] == 1'b0 && mode_o[0] == 1'b0));

  assert_reset_after_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o[2]) |-> mode_o[1]);

  assert_out_after_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o[0]) |-> (mode_o[2:1] == 2'b11));

  assert_lock_seen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mode_o[0]) && lock_present_i && $past(lock_present_i)) |-> $past(lock_i));

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_disable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && dis_req_i && !stale) |=> (mode_o == 3'b000));

  assert_enable_noop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && en_req_i && !dis_req_i && !stale && mode_o != 3'b000) |=> $stable(mode_o));

  assert_busy_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dis_req_i && mode_o != 3'b000) |=> (mode_o != 3'b000));

  assert_cfg_values_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> (m_o == '0 && n_o == MN_W'(1)));

  assert_enabled_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enabled_o) |-> done_o);

  assert_stale_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && stale) |=> (mode_o == 3'b000 && busy_o));

endmodule

bind pllseq_ctrl pllseq_ctrl_chk #(.CFG_W(CFG_W), .MN_W(MN_W)) i_pllseq_ctrl_chk (.*);

// File: tb/test_pllseq_ctrl.sv
module test_pllseq_ctrl;

  localparam int          CLK_HZ  = 1_000_000;
  localparam int          BYP_US  = 10;
  localparam int          FIX_US  = 60;
  localparam logic [31:0] CFG_V   = 32'h1234_0001;
  localparam logic [31:0] USER_V  = 32'h00A0_0000;
  localparam logic [31:0] DROOP_V = 32'h0108_C000;

  function automatic int exp_cycles(input int us);
    int c;
    c = int'((longint'(CLK_HZ) * us) / 1_000_000);
    return (c < 1) ? 1 : c;
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_req = 1'b0, dis_req = 1'b0, lock = 1'b0, lock_pres = 1'b0;
  logic [2:0]  mode;
  logic        busy, done, enabled, cfg_wr;
  logic [7:0]  m_v, n_v;
  logic [31:0] cfg_v, user_v, droop_v;

  int n_tests = 0, n_fail = 0, wd = 0;
  int lock_dly = 0, lk_cnt = 0;
  bit lock_allow = 1'b1;
  bit exp_on = 1'b0, cfg_loaded = 1'b0, cur_lp = 1'b0;

  always #5 clk = ~clk;

  pllseq_ctrl #(
    .CLK_HZ(CLK_HZ), .BYPASS_US(BYP_US), .FIXED_US(FIX_US),
    .CFG_VAL(CFG_V), .USER_VAL(USER_V), .DROOP_VAL(DROOP_V)
  ) i_pllseq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en_req), .dis_req_i(dis_req),
    .lock_i(lock), .lock_present_i(lock_pres), .mode_o(mode), .busy_o(busy),
    .done_o(done), .enabled_o(enabled), .cfg_wr_o(cfg_wr), .m_o(m_v), .n_o(n_v),
    .cfg_o(cfg_v), .user_o(user_v), .droop_o(droop_v)
  );

  // PLL model: lock rises lock_dly cycles after reset release
  always @(negedge clk) begin
    if (!mode[2]) begin
      lk_cnt <= 0;
      lock   <= 1'b0;
    end else begin
      lk_cnt <= lk_cnt + 1;
      lock   <= lock_allow && (lk_cnt >= lock_dly);
    end
  end

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd >= 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      report();
      $finish;
    end
  end

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  task automatic run_enable(input bit lp, input int ld, input bit inject);
    int t = 0, t1 = -1, t2 = -1, t0 = -1, tlk = -1;
    bit cfgw = 1'b0, ended = 1'b0;
    bit exp_cfg = !cfg_loaded;
    lock_pres = lp;
    lock_dly  = ld;
    @(negedge clk);
    en_req = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      en_req  = 1'b0;
      dis_req = (inject && t == 3);
      en_req  = (inject && t == 4);
      #1;
      t++;
      if (t == 1) check(busy == 1'b1, "R5 busy after accept", busy, 1);
      if (cfg_wr) begin
        cfgw = 1'b1;
        check(m_v == 0 && n_v == 1, "R9 m/n", {m_v, n_v}, 1);
        check(cfg_v == CFG_V && user_v == USER_V && droop_v == DROOP_V,
              "R9 cfg words", cfg_v, CFG_V);
      end
      if (mode[1] && t1 < 0) begin
        t1 = t;
        check(mode[2] == 0 && mode[0] == 0, "R2 bypass first", mode, 3'b010);
      end
      if (mode[2] && t2 < 0) t2 = t;
      if (mode[2] && !mode[0] && lock && tlk < 0) tlk = t;
      if (mode[0] && t0 < 0) t0 = t;
      check(enabled == (mode == 3'b111), "R10 enabled flag", enabled, mode == 3'b111);
      if (done) begin ended = 1'b1; break; end
    end
    dis_req = 1'b0;
    en_req  = 1'b0;
    check(ended, "R5 done pulse", ended, 1);
    check(mode == 3'b111 && !busy, "R5/R8 final mode", mode, 3'b111);
    check(t1 == (exp_cfg ? 2 : 1), "R9 bit1 delay", t1, exp_cfg ? 2 : 1);
    check(cfgw == exp_cfg, "R9 cfg write once", cfgw, exp_cfg);
    check(t2 - t1 == exp_cycles(BYP_US), "R3 bypass wait", t2 - t1, exp_cycles(BYP_US));
    if (lp) check(t0 == tlk + 1, "R4 lock wait", t0, tlk + 1);
    else    check(t0 - t2 == exp_cycles(FIX_US), "R4 fixed wait", t0 - t2, exp_cycles(FIX_US));
    sample();
    check(!done, "R5 done one cycle", done, 0);
    exp_on = 1'b1; cfg_loaded = 1'b1; cur_lp = lp;
  endtask

  task automatic run_disable();
    @(negedge clk);
    dis_req = 1'b1;
    sample();
    dis_req = 1'b0;
    check(mode == 3'b000, "R6 disable clears", mode, 0);
    check(done == 1'b1, "R6 done pulse", done, 1);
    check(!enabled, "R10 enabled low", enabled, 0);
    exp_on = 1'b0;
  endtask

  task automatic run_noop_enable();
    @(negedge clk);
    en_req = 1'b1;
    sample();
    en_req = 1'b0;
    check(mode == 3'b111 && !done && !busy, "R7 enable ignored", {done, mode}, 3'b111);
    sample();
    check(mode == 3'b111 && !done, "R7 still on", mode, 3'b111);
  endtask

  task automatic run_lock_loss();
    bit cfgw = 1'b0, ended = 1'b0;
    lock_allow = 1'b0;
    sample();  // lock low now
    sample();
    check(mode == 3'b000, "R11 forced off", mode, 0);
    for (int i = 0; i < 5; i++) begin
      if (cfg_wr) cfgw = 1'b1;
      if (done) begin ended = 1'b1; break; end
      sample();
    end
    check(cfgw && ended, "R11 config reapplied", {cfgw, ended}, 2'b11);
    lock_allow = 1'b1;
    exp_on = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    #1;
    check(mode == 3'b000 && !busy && !done && !enabled && !cfg_wr, "R1 reset outputs",
          {busy, done, mode}, 0);
    check(m_v == 0 && n_v == 0 && cfg_v == 0 && user_v == 0 && droop_v == 0,
          "R1 reset config", n_v, 0);
    rst_n = 1'b1;
    sample();

    // directed
    run_disable();
    run_enable(1'b0, 0, 1'b0);
    run_noop_enable();
    run_disable();
    run_enable(1'b1, 0, 1'b1);
    run_lock_loss();
    run_enable(1'b1, 7, 1'b0);
    run_disable();

    // random
    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: if (!exp_on) run_enable(1'($urandom_range(0, 1)), $urandom_range(0, 15),
                                   1'($urandom_range(0, 1)));
           else run_noop_enable();
        1: run_disable();
        2: if (exp_on && cur_lp) run_lock_loss();
           else begin
             sample();
             check(mode == (exp_on ? 3'b111 : 3'b000), "R10 idle hold", mode, exp_on ? 7 : 0);
           end
        default: if (exp_on) run_noop_enable();
                 else run_enable(1'b0, 0, 1'b0);
      endcase
    end

    report();
    $finish;
  end

endmodule